// File: doc/BRIEF.md
# Output Over-Current Protection Sequencer

This block watches two output-stage over-current comparator flags and turns them into graded protective actions for a full-bridge switching power stage. A low trip level makes the modulator limit current cycle by cycle. A high trip level that stays present for a qualification time puts the half bridge into high impedance. If the high level is still present after a set number of switching periods in that state, the modulator is switched off and stays off until it is cleared.

Sensing is masked for a programmable window after every output commutation, so that switching edges do not cause false trips. A trip sets a sticky status bit. A fault pin is set only when the part runs without a control bus. A crowbar enable fires only when its permission input is set. All timing is counted in clock cycles. The switching period comes in as a tick.

Top module: `ocp_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, every output is low until a qualified over-current flag arrives.
- R2: On a cycle where `commute_stb` is high, and on the BLANK_CYC cycles after it, both comparator flags are ignored.
- R3: `limit_inject` is high in the cycle after a cycle with either flag qualified (not blanked), and low otherwise. It is always low while `mod_off` is high.
- R4: `bridge_hiz` rises in the cycle after the QUAL_CYC-th consecutive cycle with `lvl2_hit` qualified. Any cycle without it restarts the count.
- R5: A temporary high-impedance state ends in the cycle after the first cycle in which `lvl2_hit` is not qualified.
- R6: While in high impedance with `lvl2_hit` still qualified, the (LATCH_PERIODS+1)-th `period_tick` sets `mod_off` from the next cycle. `mod_off` and `bridge_hiz` then stay high whatever the flags do.
- R7: `trip_status` goes high together with the entry into high impedance. It stays high until it is cleared.
- R8: `fault_o` is set on a trip only when `bus_mode` is 0 in the trip cycle. Once set, it holds until cleared.
- R9: `crowbar_fire` is set on a trip only when `crowbar_en` is 1 in the trip cycle. Once set, it holds until cleared.
- R10: `clr_trip` clears `trip_status`, `fault_o`, `crowbar_fire` and the shutdown, and returns the block to normal running from the next cycle. It takes priority over a trip in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_trip | input | 1 | Clears latched trip outputs and the permanent shutdown |
| bus_mode | input | 1 | 1 when a control bus reports status; 0 enables the fault pin |
| crowbar_en | input | 1 | Permission for the crowbar output |
| lvl1_hit | input | 1 | Low over-current threshold comparator |
| lvl2_hit | input | 1 | High over-current threshold comparator |
| period_tick | input | 1 | One-cycle pulse per switching period |
| commute_stb | input | 1 | One-cycle pulse at each output commutation |
| limit_inject | output | 1 | Cycle-by-cycle current limiting request |
| bridge_hiz | output | 1 | Half bridge held in high impedance |
| mod_off | output | 1 | Modulator permanently off |
| trip_status | output | 1 | Sticky output over-current trip status |
| fault_o | output | 1 | Fault pin for operation without a bus |
| crowbar_fire | output | 1 | Crowbar enable |

## Verification
Directed patterns hold the high flag for one cycle less than the qualification time and then for exactly that time. This separates an off-by-one error in the counter from a correct count, and a break in the middle of the hold shows whether the count restarts. Period ticks are sent one at a time during high impedance, which places the shutdown on the fifth tick and not the fourth. Strobes placed against held flags measure the blanking window at both of its edges. Random flag runs, ticks, strobes, clears and mode changes are then compared every cycle against a reference model in the bench, which reaches combinations such as a clear arriving together with a trip.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OCP_RUN = 2'b00,
    OCP_HIZ = 2'b01,
    OCP_OFF = 2'b10
  } ocp_state_e;
endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ocp_blanker.sv
module ocp_blanker #(
  parameter int BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commute_stb,
  input  logic lvl1_raw,
  input  logic lvl2_raw,
  output logic lvl1_q,
  output logic lvl2_q
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          masked;

  // count runs only while a window is open or a new one starts
  assign cnt_en = commute_stb | (cnt_q != '0);

  always_comb begin
    if (commute_stb) cnt_d = LOAD;
    else             cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign masked = commute_stb | (cnt_q != '0);
  assign lvl1_q = lvl1_raw & ~masked;
  assign lvl2_q = lvl2_raw & ~masked;

  // R2: the cycle after a strobe is still masked
  assert_blank_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commute_stb |=> (!lvl1_q && !lvl2_q));
endmodule

// File: rtl/ocp_qual_timer.sv
module ocp_qual_timer #(
  parameter int QUAL_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl2_q,
  output logic qual_met
);
  localparam int QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
  localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (!lvl2_q)      cnt_d = '0;
    else if (at_last) cnt_d = cnt_q;
    else              cnt_d = cnt_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qual_met = lvl2_q & at_last;

  generate
    if (QUAL_CYC > 1) begin : g_hist
      // R4: qualification needs the flag in the previous cycle as well
      assert_qual_hist_R4: assert property (@(posedge clk) disable iff (!rst_n)
        qual_met |-> $past(lvl2_q));
    end
  endgenerate
endmodule

// File: rtl/ocp_escalate.sv
module ocp_escalate
  import ocp_pkg::*;
#(
  parameter int LATCH_PERIODS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl1_q,
  input  logic lvl2_q,
  input  logic qual_met,
  input  logic period_tick,
  input  logic clr_trip,
  input  logic bus_mode,
  input  logic crowbar_en,
  output logic limit_inject,
  output logic bridge_hiz,
  output logic mod_off,
  output logic trip_status,
  output logic fault_o,
  output logic crowbar_fire
);
  localparam int PW = $clog2(LATCH_PERIODS + 1);
  localparam logic [PW-1:0] PLAST = PW'(LATCH_PERIODS);

  ocp_state_e    st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;
  logic          trip_ev;
  logic          lim_q, lim_d;
  logic          trip_q, trip_d;
  logic          flt_q, flt_d;
  logic          crw_q, crw_d;

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    trip_ev = 1'b0;
    if (clr_trip) begin
      st_d = OCP_RUN;
      pc_d = '0;
    end else begin
      unique case (st_q)
        OCP_RUN: begin
          if (qual_met) begin
            st_d    = OCP_HIZ;
            pc_d    = '0;
            trip_ev = 1'b1;
          end
        end
        OCP_HIZ: begin
          if (!lvl2_q) begin
            st_d = OCP_RUN;
            pc_d = '0;
          end else if (period_tick) begin
            if (pc_q == PLAST) st_d = OCP_OFF;
            else               pc_d = pc_q + PW'(1);
          end
        end
        OCP_OFF: st_d = OCP_OFF;
        default: st_d = OCP_RUN;
      endcase
    end
  end

  always_comb begin
    lim_d  = (lvl1_q | lvl2_q) & (st_d != OCP_OFF);
    trip_d = ~clr_trip & (trip_q | trip_ev);
    flt_d  = ~clr_trip & (flt_q | (trip_ev & ~bus_mode));
    crw_d  = ~clr_trip & (crw_q | (trip_ev & crowbar_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OCP_RUN;
      pc_q   <= '0;
      lim_q  <= 1'b0;
      trip_q <= 1'b0;
      flt_q  <= 1'b0;
      crw_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      lim_q  <= lim_d;
      trip_q <= trip_d;
      flt_q  <= flt_d;
      crw_q  <= crw_d;
    end
  end

  assign limit_inject = lim_q;
  assign bridge_hiz   = (st_q != OCP_RUN);
  assign mod_off      = (st_q == OCP_OFF);
  assign trip_status  = trip_q;
  assign fault_o      = flt_q;
  assign crowbar_fire = crw_q;

  assert_no_limit_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_off |-> !limit_inject);

  assert_rise_needs_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_hiz) |-> $past(qual_met));

  assert_off_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_off && !clr_trip) |=> (mod_off && bridge_hiz));

  assert_trip_on_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_hiz) |-> trip_status);

  assert_fault_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> (!$past(bus_mode) && $past(qual_met)));

  assert_crow_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crowbar_fire) |-> ($past(crowbar_en) && $past(qual_met)));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_trip |=> (!trip_status && !mod_off && !bridge_hiz && !fault_o && !crowbar_fire));
endmodule

// File: rtl/ocp_sequencer.sv
module ocp_sequencer #(
  parameter int BLANK_CYC     = 8,
  parameter int QUAL_CYC      = 200,
  parameter int LATCH_PERIODS = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_trip,
  input  logic bus_mode,
  input  logic crowbar_en,
  input  logic lvl1_hit,
  input  logic lvl2_hit,
  input  logic period_tick,
  input  logic commute_stb,
  output logic limit_inject,
  output logic bridge_hiz,
  output logic mod_off,
  output logic trip_status,
  output logic fault_o,
  output logic crowbar_fire
);
  logic rst_n;
  logic lvl1_q, lvl2_q;
  logic qual_met;

  ocp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (rst_n)
  );

  ocp_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk         (clk),
    .rst_n       (rst_n),
    .commute_stb (commute_stb),
    .lvl1_raw    (lvl1_hit),
    .lvl2_raw    (lvl2_hit),
    .lvl1_q      (lvl1_q),
    .lvl2_q      (lvl2_q)
  );

  ocp_qual_timer #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl2_q   (lvl2_q),
    .qual_met (qual_met)
  );

  ocp_escalate #(.LATCH_PERIODS(LATCH_PERIODS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl1_q       (lvl1_q),
    .lvl2_q       (lvl2_q),
    .qual_met     (qual_met),
    .period_tick  (period_tick),
    .clr_trip     (clr_trip),
    .bus_mode     (bus_mode),
    .crowbar_en   (crowbar_en),
    .limit_inject (limit_inject),
    .bridge_hiz   (bridge_hiz),
    .mod_off      (mod_off),
    .trip_status  (trip_status),
    .fault_o      (fault_o),
    .crowbar_fire (crowbar_fire)
  );

  // R1: nothing is asserted without a preceding flag
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limit_inject) |-> $past(lvl1_hit || lvl2_hit));
endmodule

// File: tb/ocp_sequencer_tb_top.sv
module ocp_sequencer_tb_top;
  localparam int B = 6;
  localparam int Q = 20;
  localparam int P = 4;

  logic clk = 1'b0;
  logic arst_n;
  logic clr_trip, bus_mode, crowbar_en, lvl1_hit, lvl2_hit, period_tick, commute_stb;
  logic limit_inject, bridge_hiz, mod_off, trip_status, fault_o, crowbar_fire;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int m_blank, m_q, m_state, m_p;
  bit m_lim, m_trip, m_flt, m_crw;

  always #5 clk = ~clk;

  ocp_sequencer #(.BLANK_CYC(B), .QUAL_CYC(Q), .LATCH_PERIODS(P)) dut_i (
    .clk(clk), .arst_n(arst_n), .clr_trip(clr_trip), .bus_mode(bus_mode),
    .crowbar_en(crowbar_en), .lvl1_hit(lvl1_hit), .lvl2_hit(lvl2_hit),
    .period_tick(period_tick), .commute_stb(commute_stb),
    .limit_inject(limit_inject), .bridge_hiz(bridge_hiz), .mod_off(mod_off),
    .trip_status(trip_status), .fault_o(fault_o), .crowbar_fire(crowbar_fire)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock step of the requirement model (state 0 run, 1 hiz, 2 off)
  task automatic model_step();
    bit blank, q1, q2, met, trip;
    int ns, np;
    blank = commute_stb || (m_blank != 0);
    q1 = lvl1_hit && !blank;
    q2 = lvl2_hit && !blank;
    met = q2 && (m_q == Q - 1);
    m_blank = commute_stb ? B : ((m_blank != 0) ? m_blank - 1 : 0);
    m_q = !q2 ? 0 : ((m_q < Q - 1) ? m_q + 1 : m_q);
    ns = m_state; np = m_p; trip = 1'b0;
    if (clr_trip) begin ns = 0; np = 0; end
    else if (m_state == 0) begin
      if (met) begin ns = 1; np = 0; trip = 1'b1; end
    end else if (m_state == 1) begin
      if (!q2) begin ns = 0; np = 0; end
      else if (period_tick) begin
        if (m_p == P) ns = 2; else np = m_p + 1;
      end
    end
    m_state = ns; m_p = np;
    m_lim = (q1 || q2) && (ns != 2);
    if (clr_trip) begin m_trip = 0; m_flt = 0; m_crw = 0; end
    else if (trip) begin
      m_trip = 1;
      if (!bus_mode) m_flt = 1;
      if (crowbar_en) m_crw = 1;
    end
  endtask

  task automatic compare_all();
    chk("R3", "limit_inject", limit_inject, m_lim);
    chk("R4", "bridge_hiz", bridge_hiz, m_state != 0);
    chk("R6", "mod_off", mod_off, m_state == 2);
    chk("R7", "trip_status", trip_status, m_trip);
    chk("R8", "fault_o", fault_o, m_flt);
    chk("R9", "crowbar_fire", crowbar_fire, m_crw);
  endtask

  // called just after a falling edge: drive, advance one clock, compare
  task automatic step(input bit l1, input bit l2, input bit tk, input bit cm, input bit cl);
    lvl1_hit = l1; lvl2_hit = l2; period_tick = tk; commute_stb = cm; clr_trip = cl;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic hold_l2(input int n, input bit tk);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, tk, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    arst_n = 1'b0;
    {clr_trip, bus_mode, crowbar_en, lvl1_hit, lvl2_hit, period_tick, commute_stb} = '0;
    m_blank = 0; m_q = 0; m_state = 0; m_p = 0;
    m_lim = 0; m_trip = 0; m_flt = 0; m_crw = 0;
    repeat (3) @(negedge clk);
    chk("R1", "bridge_hiz in reset", bridge_hiz, 1'b0);
    chk("R1", "trip_status in reset", trip_status, 1'b0);
    arst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    chk("R1", "limit_inject after reset", limit_inject, 1'b0);
    chk("R1", "fault_o after reset", fault_o, 1'b0);

    // R2 blanking window edges
    step(1, 0, 0, 1, 0);
    for (int i = 0; i < B; i++) step(1, 0, 0, 0, 0);
    chk("R2", "limit at last blanked cycle", limit_inject, 1'b0);
    step(1, 0, 0, 0, 0);
    chk("R3", "limit after blank window", limit_inject, 1'b1);
    step(0, 0, 0, 0, 0);
    chk("R3", "limit released", limit_inject, 1'b0);

    // R4 qualification boundary and restart
    hold_l2(Q - 1, 0);
    chk("R4", "hiz at Q-1", bridge_hiz, 1'b0);
    chk("R3", "limit on level two", limit_inject, 1'b1);
    step(0, 0, 0, 0, 0);
    hold_l2(Q - 1, 0);
    chk("R4", "hiz after restart Q-1", bridge_hiz, 1'b0);
    hold_l2(1, 0);
    chk("R4", "hiz at Q", bridge_hiz, 1'b1);
    chk("R7", "trip latched", trip_status, 1'b1);
    chk("R8", "fault without bus", fault_o, 1'b1);
    chk("R9", "crowbar not permitted", crowbar_fire, 1'b0);

    // R5 temporary release
    step(0, 0, 0, 0, 0);
    chk("R5", "hiz released", bridge_hiz, 1'b0);
    chk("R7", "trip held", trip_status, 1'b1);
    step(0, 0, 0, 0, 1);
    chk("R10", "trip cleared", trip_status, 1'b0);
    chk("R10", "fault cleared", fault_o, 1'b0);

    // R6 escalation with bus mode and crowbar permitted
    bus_mode = 1'b1; crowbar_en = 1'b1;
    hold_l2(Q, 0);
    chk("R8", "no fault in bus mode", fault_o, 1'b0);
    chk("R9", "crowbar fired", crowbar_fire, 1'b1);
    hold_l2(P, 1);
    chk("R6", "not off after P ticks", mod_off, 1'b0);
    hold_l2(1, 1);
    chk("R6", "off after P+1 ticks", mod_off, 1'b1);
    for (int i = 0; i < 10; i++) step(1, 0, 1, 0, 0);
    chk("R6", "off sticky", mod_off, 1'b1);
    chk("R6", "hiz sticky", bridge_hiz, 1'b1);
    chk("R3", "no limit when off", limit_inject, 1'b0);
    step(0, 0, 0, 0, 1);
    chk("R10", "off cleared", mod_off, 1'b0);
    chk("R10", "crowbar cleared", crowbar_fire, 1'b0);

    // R10 clear beats a same-cycle trip
    hold_l2(Q - 1, 0);
    step(0, 1, 0, 0, 1);
    chk("R10", "clear wins hiz", bridge_hiz, 1'b0);
    chk("R10", "clear wins trip", trip_status, 1'b0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      bit l1, l2;
      l1 = lvl1_hit; l2 = lvl2_hit;
      if ($urandom % 4 == 0) l1 = !l1;
      if ($urandom % 30 == 0) l2 = !l2;
      if ($urandom % 100 == 0) bus_mode = !bus_mode;
      if ($urandom % 100 == 0) crowbar_en = !crowbar_en;
      step(l1, l2, ($urandom % 6) == 0, ($urandom % 50) == 0, ($urandom % 150) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule